// File: doc/BRIEF.md
# Erased Sector Detector

This block runs after a BCH decoder has given up on a 512-byte flash sector. A sector that was erased and never programmed reads back as all ones in both its data and its stored parity. The parity of all-ones data is not all ones, so the decoder reports such a sector as uncorrectable. The block tells a truly damaged sector apart from a blank one. It counts the bits that read as zero in the data stream and, separately, in the parity stream that follows it. A blank sector with a few stuck or disturbed bits then becomes an erased verdict instead of a read failure.

A start pulse carries the decoder's error count. If that count is within the correction limit, nothing needs checking: the block answers at once with both flags low and takes no bytes. Otherwise it accepts `DATA_BYTES` data bytes and then `PARITY_BYTES` parity bytes over a valid/ready stream. Each byte's zero bits are added into two saturating counters. One cycle after the last parity byte is accepted, the block gives a one-cycle done pulse with its verdict:

- **erased**: the flip count is the number of zero bits in the data, and the block requests that the sector be rewritten as all ones when that count is nonzero.
- **uncorrectable**: the sector is genuinely damaged.

Top module: `erased_sector_detect`

## Requirements
- R1: A start taken while idle with `dec_errs` at or below `LIMIT` (default 8) gives `done` high in the following cycle with `erased`, `uncorrectable`, `flips` and `fill_ones` all zero, and no byte is accepted (`in_ready` stays low).
- R2: A start taken while idle with `dec_errs` above `LIMIT` raises `in_ready` in the next cycle. The block then accepts exactly `DATA_BYTES` data bytes followed by `PARITY_BYTES` parity bytes, a byte being accepted in a cycle where `in_valid` and `in_ready` are both high. After that, `in_ready` is low.
- R3: The count added for each accepted byte is the number of its bits equal to 0.
- R4: The data zero total and the parity zero total are kept apart. Each stops at `LIMIT`+1 and does not wrap, so further zero bits cannot change the verdict.
- R5: `done` is high for exactly one cycle, the cycle after the last parity byte is accepted, and is never high while `in_ready` is high.
- R6: With `done`, `erased` is set when data zeros plus parity zeros total at most `LIMIT`. Otherwise `uncorrectable` is set. The two flags are never high together.
- R7: On an erased verdict `flips` equals the data zero count. On an uncorrectable verdict `flips` is 0.
- R8: `fill_ones` (request to force the sector data to 0xFF) is high exactly when `erased` is high and `flips` is nonzero.
- R9: After reset all outputs are 0. `erased`, `uncorrectable`, `flips` and `fill_ones` hold their values after `done` until the next accepted start.
- R10: A start pulse while bytes are being accepted is ignored and does not disturb the running check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check for one sector |
| dec_errs | input | ERR_W | Error count reported by the decoder, sampled with start |
| in_valid | input | 1 | Byte on in_data is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | BYTE_W | Sector byte: data first, then parity |
| done | output | 1 | One-cycle pulse marking the verdict |
| erased | output | 1 | Sector is blank |
| uncorrectable | output | 1 | Sector is damaged beyond repair |
| flips | output | CNT_W | Number of corrected bits reported for an erased sector |
| fill_ones | output | 1 | Request to overwrite the sector data with all ones |

## Verification
The bench builds the block with its default values: 512 data bytes, 13 parity bytes, a limit of 8 and 4-bit counters. With these values, two fully zero bytes (16 zeros) would wrap an unguarded 4-bit counter back into the erased range. The non-wrapping behaviour can therefore be seen at the ports. Full-length sectors with random valid gaps exercise both stream phases and the data/parity boundary. Directed sectors place the totals at exactly 8 and at 9, split in different ways between data and parity.

// File: rtl/ezd_pkg.sv
package ezd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_PARITY = 2'd2
  } ezd_phase_e;

endpackage

// File: rtl/ezd_zero_pop.sv
module ezd_zero_pop #(
  parameter int BYTE_W = 8,
  parameter int POP_W  = $clog2(BYTE_W + 1)
) (
  input  logic [BYTE_W-1:0] in_byte,
  output logic [POP_W-1:0]  zero_cnt
);

  logic [BYTE_W-1:0] low_bit;

  genvar g;
  generate
    for (g = 0; g < BYTE_W; g++) begin : g_inv
      assign low_bit[g] = ~in_byte[g];
    end
  endgenerate

  function automatic logic [POP_W-1:0] count_set(input logic [BYTE_W-1:0] v);
    logic [POP_W-1:0] s;
    s = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      s = s + POP_W'(v[i]);
    end
    return s;
  endfunction

  assign zero_cnt = count_set(low_bit);

endmodule

// File: rtl/ezd_sat_acc.sv
module ezd_sat_acc #(
  parameter int CNT_W = 4,
  parameter int INC_W = 4,
  parameter int LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  localparam int SUM_W = (CNT_W > INC_W ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'(LIMIT + 1);

  function automatic logic [CNT_W-1:0] sat_sum(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b);
    if (s > CAP) s = CAP;
    return CNT_W'(s);
  endfunction

  always_comb begin
    if (clear)       cnt_next = '0;
    else if (add_en) cnt_next = sat_sum(cnt_q, inc);
    else             cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

endmodule

// File: rtl/ezd_seq.sv
module ezd_seq
  import ezd_pkg::*;
#(
  parameter int DATA_BYTES   = 512,
  parameter int PARITY_BYTES = 13,
  parameter int ERR_W        = 4,
  parameter int LIMIT        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ERR_W-1:0] dec_errs,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             take_data,
  output logic             take_parity,
  output logic             last_parity,
  output logic             start_take,
  output logic             skip_take
);

  localparam int MAXB  = DATA_BYTES > PARITY_BYTES ? DATA_BYTES : PARITY_BYTES;
  localparam int IDX_W = $clog2(MAXB);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_BYTES - 1);
  localparam logic [IDX_W-1:0] PAR_LAST  = IDX_W'(PARITY_BYTES - 1);

  ezd_phase_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  function automatic logic over_limit(input logic [ERR_W-1:0] e);
    return e > ERR_W'(LIMIT);
  endfunction

  assign in_ready    = (st_q == ST_DATA) || (st_q == ST_PARITY);
  assign take_data   = (st_q == ST_DATA) && in_valid;
  assign take_parity = (st_q == ST_PARITY) && in_valid;
  assign last_parity = take_parity && (idx_q == PAR_LAST);
  assign start_take  = (st_q == ST_IDLE) && start;
  assign skip_take   = start_take && !over_limit(dec_errs);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: begin
        if (start && over_limit(dec_errs)) begin
          st_d  = ST_DATA;
          idx_d = '0;
        end
      end
      ST_DATA: begin
        if (in_valid) begin
          if (idx_q == DATA_LAST) begin
            st_d  = ST_PARITY;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (in_valid) begin
          if (idx_q == PAR_LAST) begin
            st_d  = ST_IDLE;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        st_d  = ST_IDLE;
        idx_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/erased_sector_detect.sv
module erased_sector_detect #(
  parameter int DATA_BYTES   = 512,
  parameter int PARITY_BYTES = 13,
  parameter int BYTE_W       = 8,
  parameter int ERR_W        = 4,
  parameter int LIMIT        = 8,
  parameter int CNT_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ERR_W-1:0]  dec_errs,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              done,
  output logic              erased,
  output logic              uncorrectable,
  output logic [CNT_W-1:0]  flips,
  output logic              fill_ones
);

  localparam int POP_W = $clog2(BYTE_W + 1);

  logic             take_data, take_parity, last_parity, start_take, skip_take;
  logic [POP_W-1:0] byte_zeros;
  logic [CNT_W-1:0] data_cnt, data_next, par_cnt, par_next;
  logic [CNT_W:0]   zero_total;
  logic             verdict_blank;

  logic             done_q, erased_q, uncor_q, fill_q;
  logic [CNT_W-1:0] flips_q;

  ezd_seq #(
    .DATA_BYTES  (DATA_BYTES),
    .PARITY_BYTES(PARITY_BYTES),
    .ERR_W       (ERR_W),
    .LIMIT       (LIMIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dec_errs   (dec_errs),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .take_data  (take_data),
    .take_parity(take_parity),
    .last_parity(last_parity),
    .start_take (start_take),
    .skip_take  (skip_take)
  );

  ezd_zero_pop #(.BYTE_W(BYTE_W), .POP_W(POP_W)) u_pop (
    .in_byte (in_data),
    .zero_cnt(byte_zeros)
  );

  ezd_sat_acc #(.CNT_W(CNT_W), .INC_W(POP_W), .LIMIT(LIMIT)) u_data_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_take),
    .add_en  (take_data),
    .inc     (byte_zeros),
    .cnt_q   (data_cnt),
    .cnt_next(data_next)
  );

  ezd_sat_acc #(.CNT_W(CNT_W), .INC_W(POP_W), .LIMIT(LIMIT)) u_par_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_take),
    .add_en  (take_parity),
    .inc     (byte_zeros),
    .cnt_q   (par_cnt),
    .cnt_next(par_next)
  );

  function automatic logic within_limit(input logic [CNT_W:0] t);
    return t <= (CNT_W + 1)'(LIMIT);
  endfunction

  assign zero_total    = {1'b0, data_next} + {1'b0, par_next};
  assign verdict_blank = within_limit(zero_total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      erased_q <= 1'b0;
      uncor_q  <= 1'b0;
      flips_q  <= '0;
      fill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_take) begin
        done_q   <= skip_take;
        erased_q <= 1'b0;
        uncor_q  <= 1'b0;
        flips_q  <= '0;
        fill_q   <= 1'b0;
      end else if (last_parity) begin
        done_q   <= 1'b1;
        erased_q <= verdict_blank;
        uncor_q  <= !verdict_blank;
        flips_q  <= verdict_blank ? data_next : '0;
        fill_q   <= verdict_blank && (data_next != '0);
      end
    end
  end

  assign done          = done_q;
  assign erased        = erased_q;
  assign uncorrectable = uncor_q;
  assign flips         = flips_q;
  assign fill_ones     = fill_q;

endmodule

// File: rtl/erased_sector_detect_chk.sv
module erased_sector_detect_chk #(
  parameter int CNT_W = 4,
  parameter int LIMIT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_take,
  input logic             skip_take,
  input logic             last_parity,
  input logic             in_ready,
  input logic             done,
  input logic             erased,
  input logic             uncorrectable,
  input logic [CNT_W-1:0] flips,
  input logic             fill_ones,
  input logic [CNT_W-1:0] data_cnt,
  input logic [CNT_W-1:0] par_cnt
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(LIMIT + 1);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(erased && uncorrectable)); // R6

  AST_DATA_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    data_cnt <= CAP); // R4

  AST_PARITY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    par_cnt <= CAP); // R4

  AST_DATA_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cnt == CAP && !start_take) |=> data_cnt == CAP); // R4

  AST_SKIP_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    skip_take |=> (done && !erased && !uncorrectable && !in_ready)); // R1

  AST_VERDICT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_parity |=> (done && (erased || uncorrectable))); // R5

  AST_NO_DONE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !done); // R5

  AST_UNCOR_NO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> flips == '0); // R7

  AST_FILL_NEEDS_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ones |-> (erased && flips != '0)); // R8

endmodule

bind erased_sector_detect erased_sector_detect_chk #(
  .CNT_W(CNT_W),
  .LIMIT(LIMIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_take   (start_take),
  .skip_take    (skip_take),
  .last_parity  (last_parity),
  .in_ready     (in_ready),
  .done         (done),
  .erased       (erased),
  .uncorrectable(uncorrectable),
  .flips        (flips),
  .fill_ones    (fill_ones),
  .data_cnt     (data_cnt),
  .par_cnt      (par_cnt)
);

// File: tb/test_erased_sector_detect.sv
`timescale 1ns/1ps
module test_erased_sector_detect;

  localparam int DB  = 512;
  localparam int PB  = 13;
  localparam int LIM = 8;
  localparam int EW  = 4;
  localparam int CW  = 4;
  localparam int WD  = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [EW-1:0] dec_errs = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = 8'hFF;
  logic          done, erased, uncorrectable, fill_ones;
  logic [CW-1:0] flips;

  logic [7:0] dbuf [DB];
  logic [7:0] pbuf [PB];

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  erased_sector_detect #(
    .DATA_BYTES(DB), .PARITY_BYTES(PB), .BYTE_W(8),
    .ERR_W(EW), .LIMIT(LIM), .CNT_W(CW)
  ) i_erased_sector_detect (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_errs(dec_errs),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .done(done), .erased(erased), .uncorrectable(uncorrectable),
    .flips(flips), .fill_ones(fill_ones)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog: actual=%0d cycles expected<%0d", cyc, WD);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int zeros_of(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (b[i] == 1'b0) n++;
    return n;
  endfunction

  task automatic blank_all();
    for (int i = 0; i < DB; i++) dbuf[i] = 8'hFF;
    for (int i = 0; i < PB; i++) pbuf[i] = 8'hFF;
  endtask

  task automatic run_low(input logic [EW-1:0] e);
    @(negedge clk);
    start = 1'b1; dec_errs = e; in_valid = 1'b1; in_data = 8'h00;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R1 done", int'(done), 1);
    check(erased == 1'b0 && uncorrectable == 1'b0, "R1 flags", int'({erased, uncorrectable}), 0);
    check(flips == '0 && fill_ones == 1'b0, "R1 flips", int'(flips), 0);
    check(in_ready == 1'b0, "R1 no bytes", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(done == 1'b0 && in_ready == 1'b0, "R1 single pulse", int'({done, in_ready}), 0);
  endtask

  task automatic run_high(input logic [EW-1:0] e, input int inject);
    int idx = 0;
    int dz = 0;
    int pz = 0;
    bit exp_er;
    int exp_fl;
    for (int i = 0; i < DB; i++) dz += zeros_of(dbuf[i]);
    for (int i = 0; i < PB; i++) pz += zeros_of(pbuf[i]);
    exp_er = (dz + pz) <= LIM;
    exp_fl = exp_er ? dz : 0;
    @(negedge clk);
    start = 1'b1; dec_errs = e; in_valid = 1'b0;
    while (idx < DB + PB) begin
      @(negedge clk);
      if (inject >= 0 && idx == inject) begin
        start = 1'b1; dec_errs = '0;
      end else begin
        start = 1'b0;
      end
      in_valid = ($urandom % 4) != 0;
      in_data  = (idx < DB) ? dbuf[idx] : pbuf[idx - DB];
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0; start = 1'b0;
    check(done == 1'b1, "R5 done after last", int'(done), 1);
    check(in_ready == 1'b0, "R2 ready drops", int'(in_ready), 0);
    check(erased == exp_er, "R6 erased", int'(erased), int'(exp_er));
    check(uncorrectable == !exp_er, "R6 uncorrectable", int'(uncorrectable), int'(!exp_er));
    check(int'(flips) == exp_fl, "R7 flips", int'(flips), exp_fl);
    check(fill_ones == (exp_er && dz != 0), "R8 fill", int'(fill_ones), int'(exp_er && dz != 0));
    @(negedge clk);
    check(done == 1'b0, "R5 pulse width", int'(done), 0);
    @(negedge clk);
    check(erased == exp_er && int'(flips) == exp_fl, "R9 hold", int'(flips), exp_fl);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    blank_all();
    repeat (3) @(negedge clk);
    check(done == 0 && erased == 0 && uncorrectable == 0 && flips == 0 && fill_ones == 0 && in_ready == 0,
          "R9 reset", int'({done, erased, uncorrectable, fill_ones, in_ready}), 0);
    rst_n = 1'b1;

    run_low(4'd0);
    run_low(4'd8);

    blank_all();                        run_high(4'd9, -1);  // R6 all ones
    blank_all(); dbuf[0]   = 8'hFE;     run_high(4'd9, -1);  // R3 one zero
    blank_all(); dbuf[511] = 8'h00;     run_high(4'd12, -1); // R3 eight zeros in last data byte
    blank_all(); dbuf[3] = 8'h00; pbuf[0] = 8'hFE; run_high(4'd9, -1); // R6 total 9
    blank_all(); dbuf[200] = 8'hF0; pbuf[12] = 8'h0F; run_high(4'd9, -1); // R6 total 8
    blank_all(); pbuf[12] = 8'h00;      run_high(4'd10, -1); // R7 parity-only zeros
    blank_all(); dbuf[5] = 8'h00; dbuf[6] = 8'h00; run_high(4'd9, -1); // R4 16 no wrap
    blank_all(); pbuf[1] = 8'h00; pbuf[2] = 8'h00; run_high(4'd9, -1); // R4 parity 16
    blank_all(); for (int i = 0; i < 4; i++) dbuf[i] = 8'h00; run_high(4'd15, -1); // R4
    blank_all(); dbuf[50] = 8'hDB;      run_high(4'd15, 100); // R10 start ignored

    run_low(4'd3);                                            // R9 cleared by new start

    for (int s = 0; s < 18; s++) begin
      int nz;
      blank_all();
      nz = $urandom_range(12);
      for (int k = 0; k < nz; k++) begin
        int b = $urandom_range(DB + PB - 1);
        int bit_i = $urandom_range(7);
        if (b < DB) dbuf[b][bit_i] = 1'b0;
        else        pbuf[b - DB][bit_i] = 1'b0;
      end
      run_high(EW'(9 + $urandom_range(6)), -1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule